// File: doc/BRIEF.md
# Locked Two-Stage Watchdog Timer

This block is a watchdog timer that sits on a small byte-addressed register bus made of an address, write data, a write strobe and combinational read data. Once it is started, a down counter runs through two stages. First it counts down a first-stage preload. When that reaches zero it loads a second-stage preload and counts that down. When the second stage runs out, the block sets a sticky expiry flag and can drive a fixed-length reset pulse and a timeout pin.

The preloads and the control byte are guarded by a key sequence. Software writes 0x80 and then 0x86 to the key port, and only the write that comes straight after that sequence is accepted. A freeze bit in the run register holds the configuration, the preloads and the run register itself until a hardware reset. Kicks, which reload the counter, are still accepted while frozen. A prescaler divides the clock by one of two powers of two before the counter sees it. With the default coarse divider of 2^15 on a 33 MHz clock, a period of P seconds needs a first-stage count of (P*33000000 >> 15) - 1. The longest supported period is 600 seconds.

Top module: `wdl_wdog`

## Requirements
- R1: After reset every register reads 0: the preloads at 0x00 and 0x04, the control byte at 0x0d, the configuration at 0x10, the count at 0x14 and the run register at 0x18. The outputs wdt_rst_o, timeout_o and rst_warm_o are low.
- R2: A write to a guarded address (0x00, 0x04, 0x0d) takes effect only when the two writes just before it were 0x80 and then 0x86, both to the key port at 0x0c, with no other write in between. Without that sequence the guarded write is ignored.
- R3: Any of the following returns the key sequence to idle: a write to 0x0c whose byte is neither the expected next key nor 0x80 (0x80 always restarts the sequence), or a write to any other address. A guarded write uses up the key, so the next guarded write needs a new sequence.
- R4: A keyed write to 0x0d with bit 0 set reloads the counter from the first-stage preload, selects stage one and clears the prescaler.
- R5: Writing the run register 0x18 with bit 1 set while the counter is stopped loads the first-stage preload and starts counting. The count drops by one per prescaler tick. A tick comes every 2^COARSE_LOG2 clocks when configuration bit 2 is 1, and every 2^FINE_LOG2 clocks when it is 0. When the count is zero in stage one, the next tick loads the second-stage preload.
- R6: When the count is zero in stage two, the next tick sets the expiry flag and restarts stage one from the first-stage preload. If configuration bit 4 is set, wdt_rst_o is then high for RST_CYC clocks, starting the clock after the expiry. While wdt_rst_o is high, rst_warm_o follows configuration bit 3.
- R7: timeout_o is low unless configuration bit 5 is set. When bit 5 is set and run register bit 2 is 1, timeout_o follows the expiry flag. When bit 5 is set and run register bit 2 is 0, timeout_o follows the reset pulse.
- R8: The expiry flag reads in bit 1 of 0x0d, and bit 0 of 0x0d always reads 0. A keyed write to 0x0d with bit 1 set clears the flag. An expiry in the same clock wins over the clear. A clear without the key is ignored.
- R9: Writing 1 to run register bit 0 freezes the block until reset. After that, writes to 0x00, 0x04, 0x10 and 0x18 are ignored, but keyed reloads still work.
- R10: Writing 0 to 0x18 while not frozen stops the counter, and the count then holds its value.
- R11: Reads return: the preloads at 0x00 and 0x04; bits 5:2 of the configuration at 0x10, with other bits 0; the live count at 0x14, which is read-only; bits 2:0 of the run register at 0x18; 0 for unmapped addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | 6 | Byte address within the 64-byte window |
| wdata_i | input | DW | Write data (byte registers use bits 7:0) |
| we_i | input | 1 | Write strobe, one write per clock |
| rdata_o | output | DW | Read data for addr_i, combinational |
| timeout_o | output | 1 | Timeout pin |
| wdt_rst_o | output | 1 | Reset pulse on second-stage expiry |
| rst_warm_o | output | 1 | Reset kind selected while the pulse is high |

## Verification
The assertions check these properties on every cycle:
- a guarded preload write without the key leaves the preload unchanged;
- any write to a non-key address closes the key;
- an expiry always sets the flag;
- a reset pulse only ever begins right after an expiry;
- the freeze bit is sticky and holds the configuration;
- a stopped counter with no writes holds its count.

Only the bench scenarios can show the rest:
- the exact stage lengths under each divider;
- the 16-cycle pulse width;
- the broken-key cases;
- the use-once key;
- reloads still working while frozen;
- the level and pulse behaviours of the timeout pin.

These are compared clock by clock against the bench's own model.

// File: rtl/wdl_pkg.sv
package wdl_pkg;
  localparam int ADDR_W = 6;

  localparam logic [ADDR_W-1:0] A_PRE1 = 6'h00;
  localparam logic [ADDR_W-1:0] A_PRE2 = 6'h04;
  localparam logic [ADDR_W-1:0] A_KEY  = 6'h0c;
  localparam logic [ADDR_W-1:0] A_CTL  = 6'h0d;
  localparam logic [ADDR_W-1:0] A_CFG  = 6'h10;
  localparam logic [ADDR_W-1:0] A_CNT  = 6'h14;
  localparam logic [ADDR_W-1:0] A_RUN  = 6'h18;

  localparam logic [7:0] KEY_A = 8'h80;
  localparam logic [7:0] KEY_B = 8'h86;

  typedef enum logic [1:0] {UL_IDLE, UL_HALF, UL_OPEN} ul_state_e;

  // bits 5:2 of the configuration byte
  typedef struct packed {
    logic tmo_pin;
    logic rst_en;
    logic warm;
    logic coarse;
  } cfg_t;

  // bits 2:0 of the run register
  typedef struct packed {
    logic level;
    logic run;
    logic frz;
  } run_t;
endpackage

// File: rtl/wdl_unlock.sv
module wdl_unlock
  import wdl_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        byte_i,
  output logic              open_o
);
  ul_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    if (we_i) begin
      if (addr_i == A_KEY) begin
        if (byte_i == KEY_A)                          st_d = UL_HALF;
        else if (st_q == UL_HALF && byte_i == KEY_B)  st_d = UL_OPEN;
        else                                          st_d = UL_IDLE;
      end else begin
        st_d = UL_IDLE;  // guarded write consumes key; others break it
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= UL_IDLE;
    else         st_q <= st_d;
  end

  assign open_o = (st_q == UL_OPEN);
endmodule

// File: rtl/wdl_regs.sv
module wdl_regs
  import wdl_pkg::*;
#(
  parameter int DW = 32,
  parameter int CW = 24
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              open_i,
  input  logic              fire_i,
  input  logic [CW-1:0]     cnt_i,
  output logic [CW-1:0]     pre1_o,
  output logic [CW-1:0]     pre2_o,
  output cfg_t              cfg_o,
  output run_t              run_o,
  output logic              flag_o,
  output logic              reload_o,
  output logic              start_o
  ,output logic [DW-1:0]    rdata_o
);
  logic prot, wr_pre1, wr_pre2, wr_cfg, wr_run, clr;
  logic unused_wdata;

  assign unused_wdata = ^wdata_i;

  assign prot    = we_i & open_i &
                   (addr_i == A_PRE1 || addr_i == A_PRE2 || addr_i == A_CTL);
  assign wr_pre1 = prot & (addr_i == A_PRE1) & ~run_o.frz;
  assign wr_pre2 = prot & (addr_i == A_PRE2) & ~run_o.frz;
  assign wr_cfg  = we_i & (addr_i == A_CFG) & ~run_o.frz;
  assign wr_run  = we_i & (addr_i == A_RUN) & ~run_o.frz;
  assign reload_o = prot & (addr_i == A_CTL) & wdata_i[0];
  assign clr      = prot & (addr_i == A_CTL) & wdata_i[1];
  assign start_o  = wr_run & wdata_i[1] & ~run_o.run;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pre1_o <= '0;
      pre2_o <= '0;
      cfg_o  <= '0;
      run_o  <= '0;
      flag_o <= 1'b0;
    end else begin
      if (wr_pre1) pre1_o <= wdata_i[CW-1:0];
      if (wr_pre2) pre2_o <= wdata_i[CW-1:0];
      if (wr_cfg)  cfg_o  <= cfg_t'(wdata_i[5:2]);
      if (wr_run)  run_o  <= run_t'(wdata_i[2:0]);
      if (fire_i)   flag_o <= 1'b1;   // set beats clear
      else if (clr) flag_o <= 1'b0;
    end
  end

  always_comb begin
    rdata_o = '0;
    unique case (addr_i)
      A_PRE1: rdata_o[CW-1:0] = pre1_o;
      A_PRE2: rdata_o[CW-1:0] = pre2_o;
      A_CTL:  rdata_o[1]      = flag_o;
      A_CFG:  rdata_o[5:2]    = cfg_o;
      A_CNT:  rdata_o[CW-1:0] = cnt_i;
      A_RUN:  rdata_o[2:0]    = run_o;
      default: rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdl_core.sv
module wdl_core #(
  parameter int CW          = 24,
  parameter int COARSE_LOG2 = 15,
  parameter int FINE_LOG2   = 5,
  parameter int RST_CYC     = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          coarse_i,
  input  logic          rst_en_i,
  input  logic          load_i,
  input  logic [CW-1:0] pre1_i,
  input  logic [CW-1:0] pre2_i,
  output logic [CW-1:0] cnt_o,
  output logic          fire_o,
  output logic          pulse_o
);
  localparam int PW = COARSE_LOG2;
  localparam int RW = $clog2(RST_CYC + 1);
  localparam logic [PW-1:0] LIM_C = '1;
  localparam logic [PW-1:0] LIM_F = PW'((1 << FINE_LOG2) - 1);

  logic [PW-1:0] pres_q, lim;
  logic [RW-1:0] rp_q;
  logic          stage2_q, tick;

  if (FINE_LOG2 >= COARSE_LOG2) begin : g_one_div
    logic unused_sel;
    assign unused_sel = coarse_i;
    assign lim = LIM_C;
  end else begin : g_two_div
    assign lim = coarse_i ? LIM_C : LIM_F;
  end

  assign tick   = run_i & (pres_q == lim);
  assign fire_o = tick & stage2_q & (cnt_o == '0) & ~load_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_o    <= '0;
      stage2_q <= 1'b0;
      pres_q   <= '0;
    end else if (load_i) begin
      cnt_o    <= pre1_i;
      stage2_q <= 1'b0;
      pres_q   <= '0;
    end else if (!run_i) begin
      pres_q <= '0;
    end else if (tick) begin
      pres_q <= '0;
      if (cnt_o != '0) begin
        cnt_o <= cnt_o - CW'(1);
      end else if (!stage2_q) begin
        cnt_o    <= pre2_i;
        stage2_q <= 1'b1;
      end else begin
        cnt_o    <= pre1_i;
        stage2_q <= 1'b0;
      end
    end else begin
      pres_q <= pres_q + PW'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                rp_q <= '0;
    else if (fire_o && rst_en_i) rp_q <= RW'(RST_CYC);
    else if (rp_q != '0)        rp_q <= rp_q - RW'(1);
  end

  assign pulse_o = (rp_q != '0);
endmodule

// File: rtl/wdl_wdog.sv
module wdl_wdog
  import wdl_pkg::*;
#(
  parameter int DW          = 32,
  parameter int CW          = 24,
  parameter int COARSE_LOG2 = 15,
  parameter int FINE_LOG2   = 5,
  parameter int RST_CYC     = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  input  logic              we_i,
  output logic [DW-1:0]     rdata_o,
  output logic              timeout_o,
  output logic              wdt_rst_o,
  output logic              rst_warm_o
);
  logic          ul_open, fire, flag, pulse, reload, start;
  logic [CW-1:0] pre1, pre2, cnt;
  cfg_t          cfg;
  run_t          run;

  wdl_unlock u_unlock (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .byte_i (wdata_i[7:0]),
    .open_o (ul_open)
  );

  wdl_regs #(.DW(DW), .CW(CW)) u_regs (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (we_i),
    .addr_i   (addr_i),
    .wdata_i  (wdata_i),
    .open_i   (ul_open),
    .fire_i   (fire),
    .cnt_i    (cnt),
    .pre1_o   (pre1),
    .pre2_o   (pre2),
    .cfg_o    (cfg),
    .run_o    (run),
    .flag_o   (flag),
    .reload_o (reload),
    .start_o  (start),
    .rdata_o  (rdata_o)
  );

  wdl_core #(
    .CW(CW), .COARSE_LOG2(COARSE_LOG2), .FINE_LOG2(FINE_LOG2), .RST_CYC(RST_CYC)
  ) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (run.run),
    .coarse_i (cfg.coarse),
    .rst_en_i (cfg.rst_en),
    .load_i   (reload | start),
    .pre1_i   (pre1),
    .pre2_i   (pre2),
    .cnt_o    (cnt),
    .fire_o   (fire),
    .pulse_o  (pulse)
  );

  assign wdt_rst_o  = pulse;
  assign rst_warm_o = pulse & cfg.warm;
  assign timeout_o  = cfg.tmo_pin & (run.level ? flag : pulse);
endmodule

// File: rtl/wdl_chk.sv
module wdl_chk
  import wdl_pkg::*;
#(
  parameter int CW = 24
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic              open_i,
  input logic              fire_i,
  input logic              flag_i,
  input logic              pulse_i,
  input logic [2:0]        run_i,
  input logic [3:0]        cfg_i,
  input logic [CW-1:0]     pre1_i,
  input logic [CW-1:0]     cnt_i
);
  AST_KEY_REQUIRED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i && addr_i == A_PRE1 && !open_i |=> $stable(pre1_i)); // R2
  AST_KEY_CONSUMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    open_i && we_i && addr_i != A_KEY |=> !open_i); // R3
  AST_FLAG_ON_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fire_i |=> flag_i); // R6
  AST_PULSE_FROM_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pulse_i) |-> $past(fire_i)); // R6
  AST_FREEZE_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i[0] |=> run_i[0]); // R9
  AST_CFG_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    run_i[0] |=> $stable(cfg_i)); // R9
  AST_STOPPED_HOLDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i[1] && !we_i |=> $stable(cnt_i)); // R10
endmodule

bind wdl_wdog wdl_chk #(.CW(CW)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .open_i  (ul_open),
  .fire_i  (fire),
  .flag_i  (flag),
  .pulse_i (pulse),
  .run_i   (run),
  .cfg_i   (cfg),
  .pre1_i  (pre1),
  .cnt_i   (cnt)
);

// File: tb/tb_wdl_wdog.sv
module tb_wdl_wdog;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32, CW = 16, CL = 4, FL = 2;
  localparam int MASK = (1 << CW) - 1;

  logic clk = 0, rst_n = 0, we = 0;
  logic [5:0] addr = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic tmo, wrst, warm;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdl_wdog #(.DW(DW), .CW(CW), .COARSE_LOG2(CL), .FINE_LOG2(FL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .wdata_i(wdata), .we_i(we),
    .rdata_o(rdata), .timeout_o(tmo), .wdt_rst_o(wrst), .rst_warm_o(warm));

  int checks = 0, errors = 0, cyc = 0;
  bit done = 0;

  // behavioural reference model, stepped once per clock
  int m_ul, m_pre1, m_pre2, m_cfg, m_run, m_flag, m_cnt, m_st, m_pres, m_rp;
  int ad, wd, div;
  bit prot, start, reload, fire;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ul = 0; m_pre1 = 0; m_pre2 = 0; m_cfg = 0; m_run = 0;
      m_flag = 0; m_cnt = 0; m_st = 0; m_pres = 0; m_rp = 0;
    end else begin
      ad = addr; wd = wdata;
      div = m_cfg[2] ? (1 << CL) : (1 << FL);
      prot = we && m_ul == 2 && (ad == 0 || ad == 4 || ad == 13);
      start = we && ad == 24 && !m_run[0] && wd[1] && !m_run[1];
      reload = prot && ad == 13 && wd[0];
      fire = 0;
      if (start || reload) begin
        m_cnt = m_pre1; m_st = 0; m_pres = 0;
      end else if (!m_run[1]) begin
        m_pres = 0;
      end else if (m_pres == div - 1) begin
        m_pres = 0;
        if (m_cnt > 0) m_cnt = m_cnt - 1;
        else if (m_st == 0) begin m_cnt = m_pre2; m_st = 1; end
        else begin fire = 1; m_cnt = m_pre1; m_st = 0; end
      end else begin
        m_pres = (m_pres + 1) % (1 << CL);
      end
      if (fire && m_cfg[4]) m_rp = 16;
      else if (m_rp > 0) m_rp = m_rp - 1;
      if (fire) m_flag = 1;
      else if (prot && ad == 13 && wd[1]) m_flag = 0;
      if (prot && ad == 0 && !m_run[0]) m_pre1 = wd & MASK;
      if (prot && ad == 4 && !m_run[0]) m_pre2 = wd & MASK;
      if (we && ad == 16 && !m_run[0]) m_cfg = wd & 'h3C;
      if (we && ad == 24 && !m_run[0]) m_run = wd & 7;
      if (we) begin
        if (ad == 12) begin
          if ((wd & 'hFF) == 'h80) m_ul = 1;
          else if (m_ul == 1 && (wd & 'hFF) == 'h86) m_ul = 2;
          else m_ul = 0;
        end else m_ul = 0;
      end
    end
  end

  function automatic int m_read(int a);
    case (a)
      0:  return m_pre1;
      4:  return m_pre2;
      13: return m_flag << 1;
      16: return m_cfg;
      20: return m_cnt;
      24: return m_run;
      default: return 0;
    endcase
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // per-clock comparison of the outputs against the model
  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk("R6 wdt_rst_o", {31'd0, wrst}, {31'd0, m_rp != 0});
      chk("R6 rst_warm_o", {31'd0, warm}, {31'd0, (m_rp != 0) && m_cfg[3]});
      chk("R7 timeout_o", {31'd0, tmo},
          {31'd0, m_cfg[5] && (m_run[2] ? m_flag != 0 : m_rp != 0)});
    end
  end

  task automatic wr(input int a, input int d);
    addr = a; wdata = d; we = 1;
    @(negedge clk);
    we = 0;
  endtask

  task automatic key();
    wr(12, 'h80);
    wr(12, 'h86);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // read with model check and literal check
  task automatic rdx(input int a, input int exp, input string tag);
    addr = a; we = 0;
    #1;
    chk({tag, " model"}, rdata, m_read(a));
    chk(tag, rdata, exp);
    @(negedge clk);
  endtask

  task automatic rdm(input int a, input string tag, output logic [31:0] v);
    addr = a; we = 0;
    #1;
    v = rdata;
    chk(tag, rdata, m_read(a));
    @(negedge clk);
  endtask

  task automatic finish_run();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles, expected under 100000", cyc);
      finish_run();
    end
  end

  initial begin
    logic [31:0] v1, v2;
    int n;
    idle(3);
    rst_n = 1;
    idle(1);
    // R1 reset state
    rdx(0, 0, "R1 pre1"); rdx(4, 0, "R1 pre2"); rdx(13, 0, "R1 ctl");
    rdx(16, 0, "R1 cfg"); rdx(20, 0, "R1 cnt"); rdx(24, 0, "R1 run");
    chk("R1 outputs", {29'd0, tmo, wrst, warm}, 0);

    // R2 guarded write without key is ignored, with key accepted
    wr(0, 5);
    rdx(0, 0, "R2 no key");
    key(); wr(0, 7);
    key(); wr(4, 3);
    rdx(0, 7, "R2 pre1 keyed"); rdx(4, 3, "R2 pre2 keyed");

    // R3 broken sequences and use-once key
    wr(12, 'h80); wr(12, 'h85); wr(12, 'h86); wr(0, 9);
    rdx(0, 7, "R3 wrong byte");
    wr(12, 'h80); wr(16, 0); wr(12, 'h86); wr(0, 9);
    rdx(0, 7, "R3 foreign write");
    key(); wr(0, 7); wr(4, 9);
    rdx(4, 3, "R3 key consumed");

    // R11 config readback; R5 coarse counting
    wr(16, 'h3C);
    rdx(16, 'h3C, "R11 cfg");
    wr(24, 'h02);
    idle(20);
    rdx(20, 6, "R5 coarse count");

    // R6 expiry, pulse width and kind
    n = 0;
    while (!wrst && n < 1000) begin n++; @(negedge clk); end
    chk("R6 pulse seen", {31'd0, wrst}, 1);
    chk("R6 warm kind", {31'd0, warm}, 1);
    chk("R7 pin pulse", {31'd0, tmo}, 1);
    n = 0;
    while (wrst && n < 100) begin n++; @(negedge clk); end
    chk("R6 pulse width", n, 16);
    rdx(13, 2, "R6 flag set");

    // R8 clear needs key
    wr(13, 2);
    rdx(13, 2, "R8 clear without key");
    key(); wr(13, 2);
    rdx(13, 0, "R8 keyed clear");

    // R4 reload
    idle(5);
    key(); wr(13, 1);
    rdx(20, 7, "R4 reload");

    // R10 stop holds the count
    wr(24, 0);
    rdm(20, "R10 count", v1);
    idle(40);
    rdm(20, "R10 count later", v2);
    chk("R10 held", v2, v1);

    // R7 level pin, fine divider, no reset pulse
    wr(16, 'h20);
    wr(24, 'h06);
    n = 0;
    while (!tmo && n < 500) begin n++; @(negedge clk); end
    chk("R5 fine stages", n, 48);
    idle(30);
    chk("R7 level held", {31'd0, tmo}, 1);
    chk("R6 no pulse when disabled", {31'd0, wrst}, 0);
    key(); wr(13, 2);
    rdx(13, 0, "R8 clear drops pin");
    chk("R7 pin low", {31'd0, tmo}, 0);

    // R9 freeze
    wr(24, 'h03);
    rdx(24, 3, "R9 frozen");
    wr(16, 'h3C);
    rdx(16, 'h20, "R9 cfg frozen");
    key(); wr(0, 'h55);
    rdx(0, 7, "R9 pre1 frozen");
    wr(24, 0);
    rdx(24, 3, "R9 run frozen");
    key(); wr(13, 1);
    rdx(20, 7, "R9 reload while frozen");
    idle(5);
    finish_run();
  end
endmodule